// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the programmable transfer state of a single DMA channel: a 16-bit memory address and a 16-bit transfer count, each held twice, once as a base copy and once as a working copy. A host processor programs the block over an 8-bit bus. It writes each 16-bit value as two bytes, and a byte-pointer flip-flop decides which half each access reaches. The host also writes a mode byte, which chooses the transfer type, the address direction and whether autoinitialize is on.

During a transfer, the surrounding channel logic pulses `xfer_stb` once per byte moved. The working address then steps up or down inside its 64 KiB window, and the working count steps down. Terminal count is flagged on the final byte. The end of a transfer comes either from terminal count or from an external end-of-process input. At that point the channel either reloads its working values from the base copies (autoinitialize) or masks itself until the host writes the mode byte again.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, `mem_addr` is 0x0000, the channel is masked (`chan_armed` = 0), the byte pointer selects the low byte, the mode byte reads 0x00, and the status byte reads 0x02 (bit 1 = masked, bit 0 = terminal-count flag clear).
- R2: A host write with `cpu_wsel` = 0 (address) or 1 (count) loads the selected byte into both the base and the working copy. The low byte is loaded when the pointer is 0 and the high byte when it is 1. A host read with `cpu_rsel` = 0 (address) or 1 (count) returns the same byte of the working copy. Each such write or read toggles the pointer.
- R3: A host write with `cpu_wsel` = 3 clears the byte pointer, so the next address or count access reaches the low byte.
- R4: Each accepted strobe (`xfer_stb` while armed) moves the working address by one. It increments when mode bit 3 is 0 and decrements when bit 3 is 1. The address wraps within 16 bits (0xFFFF to 0x0000 upward, 0x0000 to 0xFFFF downward).
- R5: Each accepted strobe decrements the working count. `tc_out` is high during the strobe cycle in which the count is 0, so a programmed count of N gives N+1 transfers, and the count then reads 0xFFFF unless reloaded.
- R6: Terminal count sets status bit 0. A host read of the status byte (`cpu_rsel` = 2) returns the flag and then clears it.
- R7: Without autoinitialize (mode bit 2 = 0), terminal count masks the channel. While masked, strobes produce no memory strobe and no `tc_out`, and they leave the address unchanged. A write of the mode byte (`cpu_wsel` = 2) arms the channel again.
- R8: With autoinitialize (mode bit 2 = 1), terminal count reloads the working address and count from their base copies on the next edge, and the channel stays armed.
- R9: A pulse on `ext_eop` ends the transfer with the same effect as terminal count: a reload with autoinitialize, or a mask without it. It does not set status bit 0.
- R10: Mode bits [1:0] select the transfer type. 01 (write) pulses `mem_wr_stb` on each accepted strobe. 10 (read) pulses `mem_rd_stb`. 00 and 11 (verify) drive neither, but the address and count still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Host write strobe |
| cpu_wsel | input | 2 | Write target: 0 address, 1 count, 2 mode, 3 clear byte pointer |
| cpu_wdata | input | 8 | Host write data |
| cpu_rd | input | 1 | Host read strobe |
| cpu_rsel | input | 2 | Read source: 0 address, 1 count, 2 status, 3 mode |
| cpu_rdata | output | 8 | Host read data (combinational) |
| xfer_stb | input | 1 | One pulse per byte transferred |
| ext_eop | input | 1 | External end of process |
| mem_addr | output | 16 | Working memory address |
| tc_out | output | 1 | Terminal count, high during the final transfer |
| mem_wr_stb | output | 1 | Memory write strobe for I/O-to-memory transfers |
| mem_rd_stb | output | 1 | Memory read strobe for memory-to-I/O transfers |
| chan_armed | output | 1 | Channel unmasked and accepting strobes |

## Verification
The bench programs a count of 2 and checks that exactly three strobes pass with `tc_out` on the last. A design that flagged terminal count on reaching zero instead of on the transfer made at zero would end one byte early. The bench drives the address across 0x0000 to 0xFFFF downward and back upward, which exposes any carry leaking out of the 16-bit window or a swapped direction bit. Autoinitialize and end-of-process runs check that the working values return to the base copies, and not to stale host data, and that the mask stays clear. Interrupted byte sequences show whether the clear-pointer command and read-side toggling actually steer the next access to the low byte.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel address and count unit.
// Assumes an 8-bit host bus; the mode byte layout is fixed at 8 bits.
package dma_chan_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        WSEL_ADDR   = 2'd0,
        WSEL_COUNT  = 2'd1,
        WSEL_MODE   = 2'd2,
        WSEL_CLRPTR = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        RSEL_ADDR   = 2'd0,
        RSEL_COUNT  = 2'd1,
        RSEL_STATUS = 2'd2,
        RSEL_MODE   = 2'd3
    } rsel_e;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'd0,
        XF_WRITE  = 2'd1,
        XF_READ   = 2'd2,
        XF_SPARE  = 2'd3
    } xfer_e;

    typedef struct packed {
        logic [3:0] spare;
        logic       dec;
        logic       autoinit;
        xfer_e      kind;
    } mode_t;
endpackage

// File: rtl/dma_byte_ptr.sv
// Byte-pointer flip-flop: selects the low (0) or high (1) half of a
// 16-bit register for the next host access.
// Assumes clr and toggle come from the same host cycle; clr wins.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic toggle,
    output logic hi
);
    // Pointer state: reset/clear to low byte, flip on each 16-bit access.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi <= 1'b0;
        else if (clr)    hi <= 1'b0;
        else if (toggle) hi <= ~hi;
    end

    // R2: every 16-bit access flips the pointer
    p_ptr_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !clr) |=> (hi != $past(hi)));

    // R3: the clear command leaves the pointer on the low byte
    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi);
endmodule

// File: rtl/dma_word_reg.sv
// Base plus working register pair for one 16-bit channel value.
// Host byte loads write both copies; reload copies base into working;
// step moves working by one, up or down, wrapping within WORD_W bits.
// Priority: host load, then reload, then step.
module dma_word_reg #(
    parameter int DATA_W = dma_chan_pkg::BUS_W,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              reload,
    input  logic              step,
    input  logic              step_dn,
    output logic [WORD_W-1:0] cur
);
    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    logic [WORD_W-1:0] base;

    // Base copy: changed only by host byte loads.
    always_ff @(posedge clk) begin
        if (!rst_n) base <= '0;
        else if (ld_en) begin
            if (ld_hi) base[WORD_W-1:DATA_W] <= ld_data;
            else       base[DATA_W-1:0]      <= ld_data;
        end
    end

    // Working copy: host load, reload from base, or single step.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else if (ld_en) begin
            if (ld_hi) cur[WORD_W-1:DATA_W] <= ld_data;
            else       cur[DATA_W-1:0]      <= ld_data;
        end
        else if (reload) cur <= base;
        else if (step)   cur <= step_dn ? cur - ONE : cur + ONE;
    end

    // R4: upward step from all-ones wraps to zero, no carry out
    p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && !reload && !step_dn && (cur == '1)) |=> (cur == '0));

    // R4: downward step from zero wraps to all-ones
    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && !reload && step_dn && (cur == '0)) |=> (cur == '1));

    // R8: reload restores the base copy
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !ld_en) |=> (cur == $past(base)));
endmodule

// File: rtl/dma_chan_ctrl.sv
// Channel control state: mode byte, mask bit and terminal-count flag.
// Assumes end_evt already merges terminal count and external end.
// A mode write clears the mask and wins over a same-cycle end event.
module dma_chan_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  dma_chan_pkg::mode_t mode_in,
    input  logic                end_evt,
    input  logic                tc_hit,
    input  logic                stat_rd,
    output dma_chan_pkg::mode_t mode,
    output logic                armed,
    output logic                tc_flag
);
    logic masked;

    // Mode byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (mode_wr) mode <= mode_in;
    end

    // Mask: set at reset and on end without autoinitialize, cleared by mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          masked <= 1'b1;
        else if (mode_wr)                    masked <= 1'b0;
        else if (end_evt && !mode.autoinit)  masked <= 1'b1;
    end

    // Terminal-count flag: set by terminal count, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       tc_flag <= 1'b0;
        else if (tc_hit)  tc_flag <= 1'b1;
        else if (stat_rd) tc_flag <= 1'b0;
    end

    assign armed = ~masked;

    // R7: terminal count without autoinitialize masks the channel
    p_tc_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit && !mode.autoinit && !mode_wr) |=> !armed);

    // R6: terminal count always leaves the status flag set
    p_status_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_hit |=> tc_flag);

    // R6: status read with no new terminal count clears the flag
    p_status_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tc_hit) |=> !tc_flag);
endmodule

// File: rtl/dma_chan_regs.sv
// Top of the DMA channel address and count unit.
// Decodes host accesses into the byte pointer, the address and count
// register pairs and the control state; turns transfer strobes into
// address steps, count steps, terminal count and memory strobes.
// Assumes host reads and writes to 16-bit registers are not issued in
// the same cycle, and that xfer_stb is a one-cycle pulse per byte.
module dma_chan_regs #(
    parameter int DATA_W = dma_chan_pkg::BUS_W,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_wsel,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_rsel,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              xfer_stb,
    input  logic              ext_eop,
    output logic [WORD_W-1:0] mem_addr,
    output logic              tc_out,
    output logic              mem_wr_stb,
    output logic              mem_rd_stb,
    output logic              chan_armed
);
    import dma_chan_pkg::*;

    wsel_e             wsel;
    rsel_e             rsel;
    mode_t             mode;
    logic              ptr_hi;
    logic              ptr_toggle;
    logic              ptr_clr;
    logic              addr_ld;
    logic              cnt_ld;
    logic              mode_wr;
    logic              stat_rd;
    logic              accept;
    logic              tc_hit;
    logic              end_evt;
    logic              reload;
    logic              tc_flag;
    logic [WORD_W-1:0] cnt_cur;

    // Host access decode.
    always_comb begin
        wsel       = wsel_e'(cpu_wsel);
        rsel       = rsel_e'(cpu_rsel);
        addr_ld    = cpu_wr && (wsel == WSEL_ADDR);
        cnt_ld     = cpu_wr && (wsel == WSEL_COUNT);
        mode_wr    = cpu_wr && (wsel == WSEL_MODE);
        ptr_clr    = cpu_wr && (wsel == WSEL_CLRPTR);
        stat_rd    = cpu_rd && (rsel == RSEL_STATUS);
        ptr_toggle = addr_ld || cnt_ld ||
                     (cpu_rd && ((rsel == RSEL_ADDR) || (rsel == RSEL_COUNT)));
    end

    // Transfer decode: accepted strobe, terminal count and end handling.
    always_comb begin
        accept     = xfer_stb && chan_armed;
        tc_hit     = accept && (cnt_cur == '0);
        end_evt    = tc_hit || ext_eop;
        reload     = end_evt && mode.autoinit;
        tc_out     = tc_hit;
        mem_wr_stb = accept && (mode.kind == XF_WRITE);
        mem_rd_stb = accept && (mode.kind == XF_READ);
    end

    // Host read multiplexer; 16-bit values by byte pointer.
    always_comb begin
        unique case (rsel)
            RSEL_ADDR:   cpu_rdata = ptr_hi ? mem_addr[WORD_W-1:DATA_W] : mem_addr[DATA_W-1:0];
            RSEL_COUNT:  cpu_rdata = ptr_hi ? cnt_cur[WORD_W-1:DATA_W]  : cnt_cur[DATA_W-1:0];
            RSEL_STATUS: cpu_rdata = {{(DATA_W-2){1'b0}}, ~chan_armed, tc_flag};
            default:     cpu_rdata = DATA_W'(mode);
        endcase
    end

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ptr_clr),
        .toggle (ptr_toggle),
        .hi     (ptr_hi)
    );

    dma_word_reg #(.DATA_W(DATA_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (addr_ld),
        .ld_hi   (ptr_hi),
        .ld_data (cpu_wdata),
        .reload  (reload),
        .step    (accept),
        .step_dn (mode.dec),
        .cur     (mem_addr)
    );

    dma_word_reg #(.DATA_W(DATA_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (cnt_ld),
        .ld_hi   (ptr_hi),
        .ld_data (cpu_wdata),
        .reload  (reload),
        .step    (accept),
        .step_dn (1'b1),
        .cur     (cnt_cur)
    );

    dma_chan_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .mode_in (mode_t'(cpu_wdata[7:0])),
        .end_evt (end_evt),
        .tc_hit  (tc_hit),
        .stat_rd (stat_rd),
        .mode    (mode),
        .armed   (chan_armed),
        .tc_flag (tc_flag)
    );

    // R7: a masked channel stays silent on every strobe output
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_armed |-> (!mem_wr_stb && !mem_rd_stb && !tc_out));

    // R7: a masked channel does not move its address on its own
    p_masked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_armed && !cpu_wr && !ext_eop) |=> $stable(mem_addr));

    // R10: at most one memory strobe at a time
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_stb, mem_rd_stb}));

    // R5: terminal count only comes with a strobe
    p_tc_needs_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> xfer_stb);
endmodule

// File: tb/dma_chan_regs_tb_top.sv
// Directed bench for the DMA channel address and count unit.
module dma_chan_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_wsel = 2'd0;
    logic [7:0]  cpu_wdata = 8'd0;
    logic        cpu_rd = 1'b0;
    logic [1:0]  cpu_rsel = 2'd0;
    logic [7:0]  cpu_rdata;
    logic        xfer_stb = 1'b0;
    logic        ext_eop = 1'b0;
    logic [15:0] mem_addr;
    logic        tc_out;
    logic        mem_wr_stb;
    logic        mem_rd_stb;
    logic        chan_armed;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dma_chan_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr(cpu_wr), .cpu_wsel(cpu_wsel), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rsel(cpu_rsel), .cpu_rdata(cpu_rdata),
        .xfer_stb(xfer_stb), .ext_eop(ext_eop),
        .mem_addr(mem_addr), .tc_out(tc_out),
        .mem_wr_stb(mem_wr_stb), .mem_rd_stb(mem_rd_stb),
        .chan_armed(chan_armed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wsel = sel; cpu_wdata = data;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [7:0] data);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_rsel = sel;
        #1 data = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    // One transfer strobe; returns {tc_out, mem_wr_stb, mem_rd_stb} seen in its cycle.
    task automatic strobe(output logic [2:0] seen);
        @(negedge clk);
        xfer_stb = 1'b1;
        #1 seen = {tc_out, mem_wr_stb, mem_rd_stb};
        @(negedge clk);
        xfer_stb = 1'b0;
    endtask

    task automatic pulse_eop();
        @(negedge clk);
        ext_eop = 1'b1;
        @(negedge clk);
        ext_eop = 1'b0;
    endtask

    task automatic read_word(input logic [1:0] sel, output logic [15:0] w);
        logic [7:0] lo, hi;
        cpu_write(2'd3, 8'h00);
        cpu_read(sel, lo);
        cpu_read(sel, hi);
        w = {hi, lo};
    endtask

    task automatic write_word(input logic [1:0] sel, input logic [15:0] w);
        cpu_write(2'd3, 8'h00);
        cpu_write(sel, w[7:0]);
        cpu_write(sel, w[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        check("R1 addr", mem_addr, 16'h0000);
        check("R1 armed", chan_armed, 1'b0);
        cpu_read(2'd2, b);
        check("R1 status", b, 8'h02);
        cpu_read(2'd3, b);
        check("R1 mode", b, 8'h00);
    endtask

    task automatic t_program_and_run();
        logic [15:0] w;
        logic [2:0]  s;
        logic [7:0]  b;
        write_word(2'd0, 16'h1234);
        check("R2 addr port", mem_addr, 16'h1234);
        read_word(2'd0, w);
        check("R2 addr readback", w, 16'h1234);
        write_word(2'd1, 16'h0002);
        read_word(2'd1, w);
        check("R2 count readback", w, 16'h0002);
        cpu_write(2'd2, 8'h01);
        check("R7 mode write arms", chan_armed, 1'b1);
        strobe(s);
        check("R10 write strobe 1", s, 3'b010);
        strobe(s);
        check("R5 no tc on 2nd", s, 3'b010);
        strobe(s);
        check("R5 tc on 3rd", s, 3'b110);
        check("R4 addr after 3 inc", mem_addr, 16'h1237);
        check("R7 masked after tc", chan_armed, 1'b0);
        read_word(2'd1, w);
        check("R5 count rolled", w, 16'hFFFF);
        cpu_read(2'd2, b);
        check("R6 status set", b, 8'h03);
        cpu_read(2'd2, b);
        check("R6 status cleared", b, 8'h02);
        strobe(s);
        check("R7 masked strobe quiet", s, 3'b000);
        check("R7 masked addr hold", mem_addr, 16'h1237);
    endtask

    task automatic t_wrap_and_verify();
        logic [15:0] w;
        logic [2:0]  s;
        write_word(2'd0, 16'h0001);
        write_word(2'd1, 16'h0004);
        cpu_write(2'd2, 8'h0A);
        strobe(s);
        check("R10 read strobe", s, 3'b001);
        check("R4 dec to zero", mem_addr, 16'h0000);
        strobe(s);
        check("R4 dec wrap", mem_addr, 16'hFFFF);
        cpu_write(2'd2, 8'h00);
        strobe(s);
        check("R10 verify quiet", s, 3'b000);
        check("R4 inc wrap", mem_addr, 16'h0000);
        cpu_write(2'd2, 8'h03);
        strobe(s);
        check("R10 spare kind verify", s, 3'b000);
        check("R10 verify advances addr", mem_addr, 16'h0001);
        read_word(2'd1, w);
        check("R10 verify counts", w, 16'h0000);
    endtask

    task automatic t_autoinit();
        logic [15:0] w;
        logic [2:0]  s;
        logic [7:0]  b;
        write_word(2'd0, 16'h00F0);
        write_word(2'd1, 16'h0001);
        cpu_write(2'd2, 8'h05);
        strobe(s);
        check("R8 first strobe", s, 3'b010);
        strobe(s);
        check("R8 tc on 2nd", s, 3'b110);
        check("R8 addr reloaded", mem_addr, 16'h00F0);
        check("R8 stays armed", chan_armed, 1'b1);
        read_word(2'd1, w);
        check("R8 count reloaded", w, 16'h0001);
        cpu_read(2'd2, b);
        check("R6 status autoinit", b, 8'h01);
        strobe(s);
        check("R8 runs again", mem_addr, 16'h00F1);
    endtask

    task automatic t_eop();
        logic [7:0] b;
        cpu_write(2'd2, 8'h01);
        pulse_eop();
        check("R9 eop masks", chan_armed, 1'b0);
        check("R9 eop no reload", mem_addr, 16'h00F1);
        cpu_read(2'd2, b);
        check("R9 eop no tc flag", b, 8'h02);
        cpu_write(2'd2, 8'h05);
        pulse_eop();
        check("R9 eop reloads", mem_addr, 16'h00F0);
        check("R9 eop autoinit armed", chan_armed, 1'b1);
        cpu_read(2'd2, b);
        check("R9 eop autoinit no flag", b, 8'h00);
    endtask

    task automatic t_pointer();
        logic [7:0]  b;
        cpu_write(2'd3, 8'h00);
        cpu_write(2'd0, 8'hAA);
        cpu_write(2'd3, 8'h00);
        cpu_write(2'd0, 8'h55);
        cpu_write(2'd0, 8'h66);
        check("R3 clear steers low", mem_addr, 16'h6655);
        cpu_write(2'd3, 8'h00);
        cpu_read(2'd0, b);
        check("R2 read low", b, 8'h55);
        cpu_read(2'd0, b);
        check("R2 read toggles", b, 8'h66);
        cpu_write(2'd3, 8'h00);
        cpu_read(2'd0, b);
        check("R3 read after clear", b, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_and_run();
        t_wrap_and_verify();
        t_autoinit();
        t_eop();
        t_pointer();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule